// File: doc/BRIEF.md
# Pin Configuration Register Bank

This block holds the pad configuration of one general-purpose I/O port: one 16-bit configuration word per pin, reached through a simple register bus with byte-lane write strobes and a registered read path. Each word controls the pull resistor, the edge rate, the passive input filter, open-drain operation, drive strength and the function selector of its pin. It also holds a sticky freeze bit. The decoded controls go straight to the pad ring as per-pin vectors.

The bus can load one configuration into many pins in a single write. For each group of sixteen pins there is a broadcast register above the per-pin words. The upper half of the written data selects pins in that group, and the lower half is the configuration copied into every selected pin. Once a pin's freeze bit is set, that pin ignores both per-pin and broadcast writes until the next reset. The other pins selected by the same broadcast still update.

Top module: `pin_cfg_bank`

## Requirements
- R1: After reset (rst_ni low) every configuration word is 0, all pad outputs are 0 and bus_rdata_o is 0.
- R2: Word layout: pull code in bits 1:0, slow edge rate in bit 2, passive filter in bit 4, open-drain in bit 5, high drive in bit 6, function selector in bits 8+MUX_W-1:8 and freeze in bit 15. All other bits read as 0 and ignore writes. A read strobe at word address i < NUM_PINS returns {16'h0, word i} on bus_rdata_o in the following cycle. bus_rdata_o is 0 in any cycle not preceded by a read strobe.
- R3: pull_en_o is bit 1 of the pull code, and pull_up_o is high only for code 3. Code 2 gives pull-down (enabled, not up). Codes 0 and 1 give no pull.
- R4: slew_slow_o, pfilt_en_o, od_en_o and drv_hi_o follow bits 2, 4, 5 and 6 of the pin's word.
- R5: mux_o[i*MUX_W +: MUX_W] carries the function selector of pin i. dig_en_o[i] is high when that selector is non-zero; 0 means the digital function is disabled (analog use) and 1 means GPIO.
- R6: A write to word address i < NUM_PINS updates bits 7:0 when bus_be_i[0] is set and bits 15:8 when bus_be_i[1] is set. bus_be_i[3:2] have no effect. Pad outputs show the new value in the cycle after the write edge.
- R7: A write to word address NUM_PINS+g loads bus_wdata_i[15:0] into every pin 16g+k whose mask bit bus_wdata_i[16+k] is set. Byte strobes are ignored for this write, and unselected pins keep their words.
- R8: While a pin's freeze bit is set, writes of either kind leave its whole word unchanged. Only reset clears the freeze bit.
- R9: A broadcast that selects both frozen and unfrozen pins updates exactly the unfrozen ones.
- R10: Reads of the broadcast addresses, or of any address at or above NUM_PINS, return 0.
- R11: Writes to addresses at or above NUM_PINS+ceil(NUM_PINS/16) change no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte-lane write strobes |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| pull_en_o | output | NUM_PINS | Pull resistor enabled |
| pull_up_o | output | NUM_PINS | Pull direction up |
| slew_slow_o | output | NUM_PINS | Slow edge rate |
| pfilt_en_o | output | NUM_PINS | Passive input filter on |
| od_en_o | output | NUM_PINS | Open-drain output |
| drv_hi_o | output | NUM_PINS | High drive strength |
| dig_en_o | output | NUM_PINS | Digital function enabled |
| mux_o | output | NUM_PINS*MUX_W | Function selector per pin |
| lock_o | output | NUM_PINS | Freeze bit per pin |

## Verification
Every write lands on one clock edge, and the pad outputs carry the result one cycle later. Read data appears exactly one cycle after its strobe and is zero at all other times. The bench drives each operation at a falling edge, lets one rising edge pass, and samples at the next falling edge, where the result is due. It checks the full set of pad vectors after every write and the returned word after every read. Each check compares against a model that applies the byte-lane, broadcast-mask and freeze rules to its own copy of the words.

// File: rtl/pin_cfg_pkg.sv
package pin_cfg_pkg;
  localparam int CFG_W    = 16;
  localparam int GRP_PINS = 16;
  localparam int BUS_W    = 32;

  // fixed field positions (pad ring decodes these)
  localparam int PULL_LSB  = 0;
  localparam int SLEW_BIT  = 2;
  localparam int PFILT_BIT = 4;
  localparam int OD_BIT    = 5;
  localparam int DRV_BIT   = 6;
  localparam int MUX_LSB   = 8;
  localparam int LOCK_BIT  = 15;

  function automatic logic [CFG_W-1:0] wr_mask(input int mux_w);
    logic [CFG_W-1:0] m;
    m = '0;
    m[PULL_LSB +: 2] = 2'b11;
    m[SLEW_BIT]  = 1'b1;
    m[PFILT_BIT] = 1'b1;
    m[OD_BIT]    = 1'b1;
    m[DRV_BIT]   = 1'b1;
    for (int k = 0; k < mux_w; k++) m[MUX_LSB+k] = 1'b1;
    m[LOCK_BIT]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pin_cfg_wr_dec.sv
module pin_cfg_wr_dec #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [15:0]           mask_i,
  input  logic [1:0]            be_i,
  output logic [NUM_PINS-1:0]   pin_we_o,
  output logic [2*NUM_PINS-1:0] pin_be_o
);
  localparam int GRP = pin_cfg_pkg::GRP_PINS;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int G = i / GRP;
    localparam int B = i % GRP;
    logic hit_direct, hit_group;
    assign hit_direct = wr_i && (addr_i == ADDR_W'(i));
    assign hit_group  = wr_i && (addr_i == ADDR_W'(NUM_PINS + G)) && mask_i[B];
    assign pin_we_o[i]        = hit_direct | hit_group;
    // broadcast writes always load the full half-word
    assign pin_be_o[2*i +: 2] = hit_group ? 2'b11 : be_i;
  end
endmodule

// File: rtl/pin_cfg_reg.sv
module pin_cfg_reg
  import pin_cfg_pkg::*;
#(
  parameter int MUX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       be_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam logic [CFG_W-1:0] WMASK = wr_mask(MUX_W);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && !cfg_q[LOCK_BIT]) begin
      for (int b = 0; b < 2; b++) begin
        if (be_i[b]) cfg_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & WMASK[b*8 +: 8];
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pin_cfg_pad.sv
module pin_cfg_pad
  import pin_cfg_pkg::*;
#(
  parameter int MUX_W = 3
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic             pull_en_o,
  output logic             pull_up_o,
  output logic             slew_slow_o,
  output logic             pfilt_en_o,
  output logic             od_en_o,
  output logic             drv_hi_o,
  output logic             dig_en_o,
  output logic [MUX_W-1:0] mux_o,
  output logic             lock_o
);
  logic [1:0] pull_code;
  logic       unused_rsvd;

  assign pull_code   = cfg_i[PULL_LSB +: 2];
  assign pull_en_o   = pull_code[1];
  assign pull_up_o   = pull_code[1] & pull_code[0];
  assign slew_slow_o = cfg_i[SLEW_BIT];
  assign pfilt_en_o  = cfg_i[PFILT_BIT];
  assign od_en_o     = cfg_i[OD_BIT];
  assign drv_hi_o    = cfg_i[DRV_BIT];
  assign mux_o       = cfg_i[MUX_LSB +: MUX_W];
  assign dig_en_o    = |mux_o;
  assign lock_o      = cfg_i[LOCK_BIT];
  assign unused_rsvd = ^(cfg_i & ~wr_mask(MUX_W));
endmodule

// File: rtl/pin_cfg_rd.sv
module pin_cfg_rd
  import pin_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_PINS*CFG_W-1:0] cfg_flat_i,
  output logic [BUS_W-1:0]          rdata_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [CFG_W-1:0] cfg_arr [NUM_PINS];
  logic             in_range;
  logic [BUS_W-1:0] rdata_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_unpack
    assign cfg_arr[i] = cfg_flat_i[i*CFG_W +: CFG_W];
  end

  assign in_range = addr_i < ADDR_W'(NUM_PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (rd_i && in_range)  rdata_q <= {{(BUS_W-CFG_W){1'b0}}, cfg_arr[addr_i[IDX_W-1:0]]};
    else                        rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pin_cfg_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int MUX_W    = 3,
  parameter int ADDR_W   = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_wr_i,
  input  logic                      bus_rd_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [31:0]               bus_wdata_i,
  input  logic [3:0]                bus_be_i,
  output logic [31:0]               bus_rdata_o,
  output logic [NUM_PINS-1:0]       pull_en_o,
  output logic [NUM_PINS-1:0]       pull_up_o,
  output logic [NUM_PINS-1:0]       slew_slow_o,
  output logic [NUM_PINS-1:0]       pfilt_en_o,
  output logic [NUM_PINS-1:0]       od_en_o,
  output logic [NUM_PINS-1:0]       drv_hi_o,
  output logic [NUM_PINS-1:0]       dig_en_o,
  output logic [NUM_PINS*MUX_W-1:0] mux_o,
  output logic [NUM_PINS-1:0]       lock_o
);
  logic [NUM_PINS-1:0]       pin_we;
  logic [2*NUM_PINS-1:0]     pin_be;
  logic [NUM_PINS*CFG_W-1:0] cfg_flat;
  logic                      unused_be;

  assign unused_be = ^bus_be_i[3:2];

  pin_cfg_wr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .mask_i   (bus_wdata_i[31:16]),
    .be_i     (bus_be_i[1:0]),
    .pin_we_o (pin_we),
    .pin_be_o (pin_be)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_reg #(.MUX_W(MUX_W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (pin_we[i]),
      .be_i    (pin_be[2*i +: 2]),
      .wdata_i (bus_wdata_i[CFG_W-1:0]),
      .cfg_o   (cfg_flat[i*CFG_W +: CFG_W])
    );

    pin_cfg_pad #(.MUX_W(MUX_W)) u_pad (
      .cfg_i       (cfg_flat[i*CFG_W +: CFG_W]),
      .pull_en_o   (pull_en_o[i]),
      .pull_up_o   (pull_up_o[i]),
      .slew_slow_o (slew_slow_o[i]),
      .pfilt_en_o  (pfilt_en_o[i]),
      .od_en_o     (od_en_o[i]),
      .drv_hi_o    (drv_hi_o[i]),
      .dig_en_o    (dig_en_o[i]),
      .mux_o       (mux_o[i*MUX_W +: MUX_W]),
      .lock_o      (lock_o[i])
    );
  end

  pin_cfg_rd #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .cfg_flat_i (cfg_flat),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/pin_cfg_bank_chk.sv
module pin_cfg_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bus_wr_i,
  input logic                   bus_rd_i,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic [31:0]            bus_wdata_i,
  input logic [31:0]            bus_rdata_o,
  input logic [NUM_PINS*16-1:0] cfg_flat
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int G = i / 16;
    localparam int B = i % 16;

    // R8: freeze bit stays set until reset
    a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_flat[i*16+15] |=> cfg_flat[i*16+15]);

    // R8: frozen word never changes
    a_r8_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_flat[i*16+15] |=> $stable(cfg_flat[i*16 +: 16]));

    // R7: pins left out of a broadcast mask keep their word
    a_r7_unselected_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ADDR_W'(NUM_PINS + G) && !bus_wdata_i[16+B])
      |=> $stable(cfg_flat[i*16 +: 16]));
  end

  // R10: reads above the per-pin words return zero
  a_r10_high_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i >= ADDR_W'(NUM_PINS)) |=> bus_rdata_o == 32'h0);

  // R2: no read strobe, no data
  a_r2_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == 32'h0);

  // R2: upper half of read data is always zero
  a_r2_rdata_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[31:16] == 16'h0);
endmodule

bind pin_cfg_bank pin_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .cfg_flat    (cfg_flat)
);

// File: tb/pin_cfg_bank_tb_top.sv
module pin_cfg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int MW = 3;
  localparam int AW = 6;
  localparam logic [15:0] WMASK = 16'h8777;
  localparam int VW = 8*NP + NP*MW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pull_en, pull_up, slew_slow, pfilt_en, od_en, drv_hi, dig_en, lock;
  logic [NP*MW-1:0] mux;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] mdl [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_cfg_bank #(.NUM_PINS(NP), .MUX_W(MW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_be_i(bus_be),
    .bus_rdata_o(bus_rdata), .pull_en_o(pull_en), .pull_up_o(pull_up),
    .slew_slow_o(slew_slow), .pfilt_en_o(pfilt_en), .od_en_o(od_en),
    .drv_hi_o(drv_hi), .dig_en_o(dig_en), .mux_o(mux), .lock_o(lock)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete, got hang, expected end of stimulus");
    summary();
    $finish;
  end

  task automatic mdl_clear();
    for (int i = 0; i < NP; i++) mdl[i] = '0;
  endtask

  task automatic mdl_apply(input int a, input logic [31:0] d, input logic [3:0] be);
    if (a < NP) begin
      if (!mdl[a][15])
        for (int b = 0; b < 2; b++)
          if (be[b]) mdl[a][b*8 +: 8] = d[b*8 +: 8] & WMASK[b*8 +: 8];
    end else if (a < NP + NP/16) begin
      for (int k = 0; k < 16; k++) begin
        int p = (a - NP)*16 + k;
        if (d[16+k] && !mdl[p][15]) mdl[p] = d[15:0] & WMASK;
      end
    end
  endtask

  function automatic logic [VW-1:0] exp_vec();
    logic [NP-1:0] pe, pu, sl, pf, od, dr, de, lk;
    logic [NP*MW-1:0] mx;
    for (int i = 0; i < NP; i++) begin
      pe[i] = mdl[i][1];
      pu[i] = mdl[i][1] & mdl[i][0];
      sl[i] = mdl[i][2];
      pf[i] = mdl[i][4];
      od[i] = mdl[i][5];
      dr[i] = mdl[i][6];
      mx[i*MW +: MW] = mdl[i][10:8];
      de[i] = |mdl[i][10:8];
      lk[i] = mdl[i][15];
    end
    return {pe, pu, sl, pf, od, dr, de, lk, mx};
  endfunction

  task automatic check_pads(input string tag);
    logic [VW-1:0] act, exp;
    act = {pull_en, pull_up, slew_slow, pfilt_en, od_en, drv_hi, dig_en, lock, mux};
    exp = exp_vec();
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s pads: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    mdl_clear();
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
    mdl_apply(a, d, be);
  endtask

  task automatic do_read(input int a, output logic [31:0] r);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    r = bus_rdata;
  endtask

  task automatic read_check(input int a, input logic [31:0] exp, input string tag);
    logic [31:0] r;
    do_read(a, r);
    check32(tag, r, exp);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    mdl_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    check_pads("R1 reset");
    check32("R1 rdata idle", bus_rdata, 32'h0);
    rst_ni = 1'b1;
    read_check(0, 32'h0, "R1 pin0 word");

    // R6 / R2 byte lanes and reserved bits
    do_write(2, 32'hFFFF_FFFF, 4'b0001);
    read_check(2, 32'h0000_0077, "R2 reserved low byte");
    check_pads("R4 field bits");
    do_write(5, 32'h0000_7F00, 4'b0010);
    read_check(5, 32'h0000_0700, "R6 upper lane only");
    check_pads("R5 mux field");
    do_write(2, 32'h0000_0001, 4'b1100);
    read_check(2, 32'h0000_0077, "R6 upper strobes ignored");

    // R3 pull codes
    do_write(7, 32'h1, 4'b0011);
    do_write(8, 32'h2, 4'b0011);
    do_write(9, 32'h3, 4'b0011);
    check32("R3 pull codes",
            {29'h0, pull_en[7], pull_en[8], pull_up[8]}, 32'h2);
    check32("R3 pull-up code", {30'h0, pull_en[9], pull_up[9]}, 32'h3);
    check_pads("R3 pads");

    // R7 broadcast writes
    do_write(NP, 32'h0005_0142, 4'b0000);
    check_pads("R7 low group");
    read_check(0, 32'h0000_0142, "R7 selected pin0");
    read_check(1, 32'h0000_0000, "R7 unselected pin1");
    do_write(NP+1, 32'h8001_0231, 4'b0000);
    read_check(31, 32'h0000_0231, "R7 high group pin31");
    read_check(17, 32'h0000_0000, "R7 high group pin17");

    // R8 freeze
    do_write(3, 32'h0000_8123, 4'b0011);
    read_check(3, 32'h0000_8123, "R8 lock written");
    do_write(3, 32'h0000_0000, 4'b0011);
    read_check(3, 32'h0000_8123, "R8 locked direct");
    // R9 mixed broadcast
    do_write(NP, 32'h0018_0064, 4'b1111);
    read_check(3, 32'h0000_8123, "R9 locked pin held");
    read_check(4, 32'h0000_0064, "R9 unlocked pin written");
    check_pads("R9 pads");

    // R10 / R11
    read_check(NP, 32'h0, "R10 broadcast read");
    read_check(40, 32'h0, "R10 unmapped read");
    do_write(40, 32'hFFFF_FFFF, 4'b1111);
    check_pads("R11 unmapped write");

    do_reset();
    check_pads("R1 after reset");
    do_write(3, 32'h0000_0001, 4'b0011);
    read_check(3, 32'h0000_0001, "R8 reset clears lock");

    // random mix
    for (int n = 0; n < 800; n++) begin
      int a;
      logic [31:0] d;
      if (n % 200 == 199) do_reset();
      a = int'($urandom_range(0, NP + 3));
      d = $urandom();
      if ($urandom_range(0, 7) != 0) d[15] = 1'b0;
      if ($urandom_range(0, 2) == 0) begin
        do_read(a, r);
        check32("R2/R10 random read", r, (a < NP) ? {16'h0, mdl[a]} : 32'h0);
      end else begin
        do_write(a, d, 4'($urandom()));
        check_pads("R6/R7/R8 random write");
      end
    end

    summary();
    $finish;
  end
endmodule